// File: doc/BRIEF.md
# Cell Sync Receive Word Checker

This block watches the receive side of a 32-bit word-wide backplane link running in cell mode. Each cycle that the upstream logic marks as valid, it takes one word together with its 2-bit overhead type and sorts it into one of three classes: data, command, or IDLE. An IDLE is a command word with a fixed fill pattern. The block reports the class one cycle later on registered outputs. For an IDLE it also drives a dedicated active-low flag.

Alongside the classification, the block counts valid words through a cell period whose length in words is set at an input. When an IDLE lands in the final slot of a period, its two low bits must carry the cell-clock marker (both bits set). If they do not, the block raises a one-cycle sync error pulse. A marked IDLE that arrives anywhere else realigns the count: that word becomes the final slot of the period. A sticky flag records that such a realignment has happened.

Top module: `cellsync_rx_checker`

## Requirements
- R1: A valid word whose type is 01, 10 or 11 drives `out_is_data` high and `out_is_cmd` low, with `out_valid` high, on the cycle after it is presented.
- R2: A valid word whose type is 00 drives `out_is_cmd` high and `out_is_data` low, with `out_valid` high, on the cycle after it is presented.
- R3: A valid word is an IDLE when its type is 00 and its bits [31:2] are all ones. For such a word, `idle_n` goes low for exactly the following cycle. For every other word, including a type-nonzero word with the same bit pattern, `idle_n` stays high.
- R4: A valid IDLE in the final slot whose bits [1:0] are not 11 produces `sync_err` high for exactly the cycle after it is presented.
- R5: No error is produced by any of these: a data word in the final slot, a non-IDLE command in the final slot, a marked IDLE in the final slot, or an unmarked IDLE outside the final slot.
- R6: Slots are numbered 0 to L-1 over valid words, where L is `cell_len`. A `cell_len` of 0 behaves as 1. After the final slot, the count returns to 0. With L = 1 every valid word sits in the final slot.
- R7: A valid IDLE with bits [1:0] = 11 that is not in the final slot is treated as the final slot, so the next valid word is slot 0. `resync_seen` goes high on the following cycle and stays high until reset.
- R8: While `in_valid` is low, the slot count does not advance, and on the next cycle `out_valid`, `out_is_data`, `out_is_cmd` and `sync_err` are low and `idle_n` is high.
- R9: While `rst_n` is low, `out_valid`, `out_is_data`, `out_is_cmd`, `sync_err` and `resync_seen` are low and `idle_n` is high. The slot count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the received word this cycle |
| in_word | input | 32 | Received word |
| in_type | input | 2 | Overhead type bits of the received word |
| cell_len | input | CNT_W | Cell period length in words (0 treated as 1) |
| out_valid | output | 1 | Registered copy of the qualifier |
| out_is_data | output | 1 | Previous word was data |
| out_is_cmd | output | 1 | Previous word was a command |
| idle_n | output | 1 | Low when previous word was an IDLE |
| sync_err | output | 1 | One-cycle pulse on a cell sync error |
| resync_seen | output | 1 | Sticky: slot count was realigned by a marked IDLE |

## Verification
The hardest situation to reach from the ports is an unmarked IDLE that lands exactly on the final slot after the count has been realigned. The stimulus first walks the count to a middle slot. It then sends a marked IDLE there, counts three more words from the new origin, and places an unmarked IDLE on what is now the last slot. Invalid cycles are inserted inside a period, carrying IDLE payloads, to show that the position does not shift. The length is also switched to 1 and to 0 so that consecutive words each hit the final slot.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int WORD_W = 32;
  localparam int TYPE_W = 2;
  localparam logic [WORD_W-3:0] IDLE_FILL = '1;
  localparam logic [1:0] MARK_BITS = 2'b11;

  function automatic logic type_is_data(input logic [TYPE_W-1:0] t);
    return t != '0;
  endfunction

  function automatic logic word_is_idle(input logic [TYPE_W-1:0] t,
                                        input logic [WORD_W-1:0] w);
    return (t == '0) && (w[WORD_W-1:2] == IDLE_FILL);
  endfunction

  function automatic logic word_has_mark(input logic [WORD_W-1:0] w);
    return w[1:0] == MARK_BITS;
  endfunction
endpackage

// File: rtl/cs_word_class.sv
module cs_word_class
  import cs_pkg::*;
(
  input  logic              valid,
  input  logic [TYPE_W-1:0] wtype,
  input  logic [WORD_W-1:0] word,
  output logic              is_data,
  output logic              is_cmd,
  output logic              is_idle,
  output logic              has_mark
);
  always_comb begin
    is_data  = valid && type_is_data(wtype);
    is_cmd   = valid && !type_is_data(wtype);
    is_idle  = valid && word_is_idle(wtype, word);
    has_mark = word_has_mark(word);
  end
endmodule

// File: rtl/cs_slot_track.sv
module cs_slot_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             mark_idle,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] slot_q,
  output logic             at_last,
  output logic             resync_ev,
  output logic             resync_q
);
  localparam int EXT_W = CNT_W + 1;

  function automatic logic slot_is_last(input logic [CNT_W-1:0] s,
                                        input logic [CNT_W-1:0] l);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, s} + EXT_W'(1);
    return nxt >= {1'b0, l};
  endfunction

  always_comb begin
    at_last   = slot_is_last(slot_q, len);
    resync_ev = step && mark_idle && !at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      resync_q <= 1'b0;
    end else if (step) begin
      if (at_last || resync_ev) slot_q <= '0;
      else                      slot_q <= slot_q + CNT_W'(1);
      if (resync_ev) resync_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cs_out_stage.sv
module cs_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_data,
  input  logic is_cmd,
  input  logic is_idle,
  input  logic err_ev,
  output logic out_valid,
  output logic out_is_data,
  output logic out_is_cmd,
  output logic idle_n,
  output logic sync_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_data <= 1'b0;
      out_is_cmd  <= 1'b0;
      idle_n      <= 1'b1;
      sync_err    <= 1'b0;
    end else begin
      out_valid   <= valid;
      out_is_data <= is_data;
      out_is_cmd  <= is_cmd;
      idle_n      <= !is_idle;
      sync_err    <= err_ev;
    end
  end
endmodule

// File: rtl/cellsync_rx_checker.sv
module cellsync_rx_checker
  import cs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [CNT_W-1:0]  cell_len,
  output logic              out_valid,
  output logic              out_is_data,
  output logic              out_is_cmd,
  output logic              idle_n,
  output logic              sync_err,
  output logic              resync_seen
);
  logic             w_is_data;
  logic             w_is_cmd;
  logic             w_is_idle;
  logic             w_has_mark;
  logic             w_at_last;
  logic             w_resync_ev;
  logic             w_err_ev;
  logic [CNT_W-1:0] w_slot;

  cs_word_class u_class (
    .valid    (in_valid),
    .wtype    (in_type),
    .word     (in_word),
    .is_data  (w_is_data),
    .is_cmd   (w_is_cmd),
    .is_idle  (w_is_idle),
    .has_mark (w_has_mark)
  );

  cs_slot_track #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (in_valid),
    .mark_idle (w_is_idle && w_has_mark),
    .len       (cell_len),
    .slot_q    (w_slot),
    .at_last   (w_at_last),
    .resync_ev (w_resync_ev),
    .resync_q  (resync_seen)
  );

  assign w_err_ev = w_is_idle && w_at_last && !w_has_mark;

  cs_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (in_valid),
    .is_data     (w_is_data),
    .is_cmd      (w_is_cmd),
    .is_idle     (w_is_idle),
    .err_ev      (w_err_ev),
    .out_valid   (out_valid),
    .out_is_data (out_is_data),
    .out_is_cmd  (out_is_cmd),
    .idle_n      (idle_n),
    .sync_err    (sync_err)
  );
endmodule

// File: rtl/cs_sync_chk.sv
module cs_sync_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_type,
  input logic             out_valid,
  input logic             out_is_data,
  input logic             out_is_cmd,
  input logic             idle_n,
  input logic             sync_err,
  input logic             resync_seen,
  input logic             err_ev,
  input logic             resync_ev,
  input logic             at_last,
  input logic [CNT_W-1:0] slot_q
);
  a_r1_data_type: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_type != 2'b00) |=> out_valid && out_is_data && !out_is_cmd);

  a_r2_cmd_type: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_type == 2'b00) |=> out_valid && out_is_cmd && !out_is_data);

  a_r3_idle_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_n |-> out_valid && out_is_cmd);

  a_r4_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    err_ev |=> sync_err);

  a_r4_err_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !idle_n);

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && at_last |=> slot_q == '0);

  a_r7_resync_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resync_ev |=> slot_q == '0 && resync_seen);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    resync_seen |=> resync_seen);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && idle_n && !sync_err && $stable(slot_q));
endmodule

bind cellsync_rx_checker cs_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_type     (in_type),
  .out_valid   (out_valid),
  .out_is_data (out_is_data),
  .out_is_cmd  (out_is_cmd),
  .idle_n      (idle_n),
  .sync_err    (sync_err),
  .resync_seen (resync_seen),
  .err_ev      (w_err_ev),
  .resync_ev   (w_resync_ev),
  .at_last     (w_at_last),
  .slot_q      (w_slot)
);

// File: tb/cellsync_rx_checker_test.sv
module cellsync_rx_checker_test;
  localparam int CNT_W = 8;
  localparam realtime HALF = 10ns;
  localparam logic [31:0] IDLE0 = 32'hFFFF_FFFC;

  typedef struct {
    logic  v, d, c, idn, err, rs;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [31:0]      in_word = '0;
  logic [1:0]       in_type = '0;
  logic [CNT_W-1:0] cell_len = 8'd4;
  logic out_valid, out_is_data, out_is_cmd, idle_n, sync_err, resync_seen;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t q[$];
  int   m_slot = 0;
  logic m_res = 1'b0;

  always #HALF clk = ~clk;

  cellsync_rx_checker #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_type(in_type), .cell_len(cell_len), .out_valid(out_valid),
    .out_is_data(out_is_data), .out_is_cmd(out_is_cmd), .idle_n(idle_n),
    .sync_err(sync_err), .resync_seen(resync_seen)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: reference model computes the expected outputs and queues them.
  task automatic drive(input logic v, input logic [1:0] t, input logic [31:0] w, input string tag);
    exp_t e;
    logic idle, mark, last;
    int   len;
    @(negedge clk);
    len  = (cell_len == 0) ? 1 : int'(cell_len);
    idle = v && (t == 2'b00) && (w[31:2] == 30'h3FFF_FFFF);
    mark = (w[1:0] == 2'b11);
    last = (m_slot == len - 1) || (m_slot >= len);
    e.v   = v;
    e.d   = v && (t != 2'b00);
    e.c   = v && (t == 2'b00);
    e.idn = !idle;
    e.err = idle && last && !mark;
    if (v) begin
      if (last) m_slot = 0;
      else if (idle && mark) begin m_slot = 0; m_res = 1'b1; end
      else m_slot++;
    end
    e.rs  = m_res;
    e.tag = tag;
    in_valid = v; in_type = t; in_word = w;
    q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic check_reset(input string tag);
    #1ns;
    chk(tag, "out_valid", out_valid, 1'b0);
    chk(tag, "out_is_data", out_is_data, 1'b0);
    chk(tag, "out_is_cmd", out_is_cmd, 1'b0);
    chk(tag, "idle_n", idle_n, 1'b1);
    chk(tag, "sync_err", sync_err, 1'b0);
    chk(tag, "resync_seen", resync_seen, 1'b0);
  endtask

  // Monitor: compares after each active edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2ns;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "out_valid", out_valid, e.v);
        chk(e.tag, "out_is_data", out_is_data, e.d);
        chk(e.tag, "out_is_cmd", out_is_cmd, e.c);
        chk(e.tag, "idle_n", idle_n, e.idn);
        chk(e.tag, "sync_err", sync_err, e.err);
        chk(e.tag, "resync_seen", resync_seen, e.rs);
      end
    end
  end

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check_reset("R9");
    @(negedge clk);
    rst_n = 1'b1;

    // period of 4: data types then marked IDLE in last slot
    drive(1, 2'b01, 32'h0000_0001, "R1");
    drive(1, 2'b10, 32'hA5A5_5A5A, "R1");
    drive(1, 2'b11, 32'hFFFF_FFFF, "R1");
    drive(1, 2'b00, IDLE0 | 32'd3, "R5");
    // command, gap, unmarked IDLE mid period, data, unmarked IDLE last
    drive(1, 2'b00, 32'h1234_5678, "R2");
    drive(0, 2'b00, IDLE0, "R8");
    drive(1, 2'b00, IDLE0, "R3");
    drive(1, 2'b01, IDLE0 | 32'd3, "R3");
    drive(1, 2'b00, IDLE0 | 32'd1, "R4");
    // data and non-IDLE command in last slot
    drive(1, 2'b01, 32'h0, "R6");
    drive(1, 2'b01, 32'h1, "R6");
    drive(1, 2'b01, 32'h2, "R6");
    drive(1, 2'b10, 32'h3, "R5");
    drive(1, 2'b00, 32'h10, "R2");
    drive(1, 2'b00, 32'h20, "R2");
    drive(0, 2'b00, IDLE0, "R8");
    drive(0, 2'b00, IDLE0 | 32'd2, "R8");
    drive(1, 2'b00, 32'h30, "R2");
    drive(1, 2'b00, 32'hFFFF_FFF0, "R5");
    // realignment at slot 1, then error on the new last slot
    drive(1, 2'b11, 32'h0, "R6");
    drive(1, 2'b00, IDLE0 | 32'd3, "R7");
    drive(1, 2'b01, 32'h0, "R7");
    drive(1, 2'b01, 32'h1, "R7");
    drive(1, 2'b01, 32'h2, "R7");
    drive(1, 2'b00, IDLE0 | 32'd2, "R7");
    settle();

    // length 1: every word is last
    cell_len = 8'd1;
    drive(1, 2'b00, IDLE0, "R6");
    drive(1, 2'b00, IDLE0 | 32'd1, "R6");
    drive(1, 2'b00, IDLE0 | 32'd3, "R6");
    settle();
    // length 0 behaves as 1
    cell_len = 8'd0;
    drive(1, 2'b00, IDLE0 | 32'd2, "R6");
    drive(1, 2'b00, IDLE0 | 32'd3, "R6");
    drive(1, 2'b01, IDLE0, "R6");
    settle();

    // reset mid-run, then length 3
    @(negedge clk);
    rst_n = 1'b0;
    check_reset("R9");
    q.delete();
    m_slot = 0;
    m_res  = 1'b0;
    cell_len = 8'd3;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 2'b01, 32'h7, "R9");
    drive(1, 2'b01, 32'h8, "R6");
    drive(1, 2'b00, IDLE0, "R4");
    drive(1, 2'b00, IDLE0, "R5");
    settle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule